// File: doc/BRIEF.md
# Fragment Thread Scheduler with Texture-Fetch Parking

This block keeps the live fragment contexts for one fragment shading core. Every fragment from the rasterizer stream becomes its own thread in a context slot, and threads never share data. Each cycle the block offers one runnable thread to the execution pipe. In the same cycle the pipe answers with a rewritten context and a flag that says whether the thread has just issued a texture fetch. A fetching thread is parked and a fetch request tagged with its slot number goes to memory. The core then runs other threads and never waits on a miss. A tagged memory response wakes its slot, and responses may come back in any order.

A thread that finishes without fetching is marked done. Done threads leave on an output stream in the exact order their fragments arrived, so a fast young fragment waits behind a slow old one. Retiring a thread releases its slot for a new fragment. The default pool holds 64 slots of 32-bit context, which leaves room for enough threads in flight to cover long memory latencies.

Top module: `fts_sched`

## Requirements
- R1: After reset every slot is free: `frag_ready_o` is 1, and `iss_valid_o`, `tex_req_valid_o` and `out_valid_o` are 0.
- R2: `frag_ready_o` is 1 exactly when at least one slot is free. A fragment is taken only on a cycle with `frag_valid_i` and `frag_ready_o` both high. It goes into the lowest-numbered free slot, and that slot number is the thread's tag from then on.
- R3: At most one thread is issued per cycle, and only from a slot that is runnable. `iss_valid_o` is 1 whenever a runnable slot exists. `iss_ctx_o` carries that slot's current context, which is the accepted fragment data on its first issue.
- R4: Issue is round-robin. The slot issued is the first runnable slot found when scanning upward from one past the previously issued tag, wrapping from NUM_SLOTS-1 to 0. The scan starts at slot 0 after reset.
- R5: If `iss_fetch_i` is 1 during an issue, `tex_req_valid_o` is 1 in that cycle with `tex_req_tag_o` equal to `iss_tag_o`. The slot is parked and is not issued again until its response arrives. If `iss_fetch_i` is 0, no request is made and the thread becomes done.
- R6: A response (`tex_rsp_valid_i`) whose tag names a parked slot makes that slot runnable from the next cycle on, whatever order the responses come in. A response naming a slot that is not parked has no effect.
- R7: `out_valid_o` is 1 only when the oldest unretired fragment is done. Threads retire strictly in arrival order. An offered thread and its `out_ctx_o` are held while `out_ready_i` is 0.
- R8: A retire (`out_valid_o` and `out_ready_i`) frees the slot at that clock edge, so the slot can accept a fragment from the next cycle on.
- R9: On every issue `iss_ctx_i` replaces the slot's context. The retired `out_ctx_o` is the context written by the thread's final, non-fetching issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frag_valid_i | input | 1 | Incoming fragment present |
| frag_ready_o | output | 1 | A free slot exists; fragment taken this cycle |
| frag_ctx_i | input | CTX_W | Incoming fragment context |
| iss_valid_o | output | 1 | A thread is issued this cycle |
| iss_tag_o | output | TAG_W | Slot of the issued thread |
| iss_ctx_o | output | CTX_W | Context of the issued thread |
| iss_fetch_i | input | 1 | Issued thread makes a texture fetch and parks |
| iss_ctx_i | input | CTX_W | Rewritten context from the execution pipe |
| tex_req_valid_o | output | 1 | Texture fetch request |
| tex_req_tag_o | output | TAG_W | Slot tag carried by the request |
| tex_rsp_valid_i | input | 1 | Texture response present |
| tex_rsp_tag_i | input | TAG_W | Slot tag of the response |
| out_valid_o | output | 1 | Oldest thread is done and offered |
| out_ready_i | input | 1 | Output stream accepts |
| out_ctx_o | output | CTX_W | Context of the retiring thread |

## Verification
The bench runs an 8-slot pool in three patterns. The first is a fill burst of non-fetching fragments with the output stalled. It separates correct full-pool back-pressure, lowest-slot allocation and plain rotating issue from off-by-one errors in the slot count or the pointer. Stray responses to slots that are not parked are injected during this burst, which shows that they are ignored.

The second pattern is a long run with zero to three fetches per fragment, random memory latency, random response choice and random output stalls. It separates true per-tag wakeup and arrival-order retirement from designs that assume responses come back in order or that retire in completion order. The third pattern drains the pool and confirms that every accepted fragment leaves exactly once.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_READY = 2'd1,
    SLOT_WAIT  = 2'd2,
    SLOT_DONE  = 2'd3
  } slot_state_e;
endpackage

// File: rtl/fts_pick.sv
// Rotating first-set finder: scans req_i upward from base_i with wrap.
module fts_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] base_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  int k;
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    k       = 0;
    for (int i = 0; i < N; i++) begin
      k = int'(base_i) + i;
      if (k >= N) k = k - N;
      if (!found_o && req_i[k]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/fts_order_fifo.sv
// Arrival-order queue of slot tags.
module fts_order_fifo #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_tag_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int CNT_W = $clog2(N + 1);

  logic [IDX_W-1:0] mem_q [N];
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_tag_i;
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/fts_sched.sv
module fts_sched
  import fts_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int CTX_W     = 32,
  localparam int TAG_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frag_valid_i,
  output logic             frag_ready_o,
  input  logic [CTX_W-1:0] frag_ctx_i,
  output logic             iss_valid_o,
  output logic [TAG_W-1:0] iss_tag_o,
  output logic [CTX_W-1:0] iss_ctx_o,
  input  logic             iss_fetch_i,
  input  logic [CTX_W-1:0] iss_ctx_i,
  output logic             tex_req_valid_o,
  output logic [TAG_W-1:0] tex_req_tag_o,
  input  logic             tex_rsp_valid_i,
  input  logic [TAG_W-1:0] tex_rsp_tag_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [CTX_W-1:0] out_ctx_o
);
  slot_state_e      st_q  [NUM_SLOTS];
  logic [CTX_W-1:0] ctx_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] free_vec, ready_vec;
  logic [TAG_W-1:0] rr_q, alloc_idx, head_tag;
  logic alloc_found, accept, retire, rsp_hit, q_empty, q_full;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_vec
    assign free_vec[g]  = (st_q[g] == SLOT_FREE);
    assign ready_vec[g] = (st_q[g] == SLOT_READY);
  end

  fts_pick #(.N(NUM_SLOTS), .IDX_W(TAG_W)) u_alloc (
    .req_i(free_vec), .base_i('0), .found_o(alloc_found), .idx_o(alloc_idx));

  fts_pick #(.N(NUM_SLOTS), .IDX_W(TAG_W)) u_issue (
    .req_i(ready_vec), .base_i(rr_q), .found_o(iss_valid_o), .idx_o(iss_tag_o));

  assign frag_ready_o    = alloc_found;
  assign accept          = frag_valid_i && alloc_found;
  assign iss_ctx_o       = ctx_q[iss_tag_o];
  assign tex_req_valid_o = iss_valid_o && iss_fetch_i;
  assign tex_req_tag_o   = iss_tag_o;
  assign rsp_hit         = tex_rsp_valid_i && (st_q[tex_rsp_tag_i] == SLOT_WAIT);

  fts_order_fifo #(.N(NUM_SLOTS), .IDX_W(TAG_W)) u_order (
    .clk_i, .rst_ni,
    .push_i(accept), .push_tag_i(alloc_idx),
    .pop_i(retire), .head_o(head_tag),
    .empty_o(q_empty), .full_o(q_full));

  assign out_valid_o = !q_empty && (st_q[head_tag] == SLOT_DONE);
  assign out_ctx_o   = ctx_q[head_tag];
  assign retire      = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (iss_valid_o)
      rr_q <= (iss_tag_o == TAG_W'(NUM_SLOTS - 1)) ? '0 : iss_tag_o + 1'b1;
  end

  // The four events hit distinct slots: each needs a different current state.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= SLOT_FREE;
      else if (accept && alloc_idx == TAG_W'(g))
        st_q[g] <= SLOT_READY;
      else if (iss_valid_o && iss_tag_o == TAG_W'(g))
        st_q[g] <= iss_fetch_i ? SLOT_WAIT : SLOT_DONE;
      else if (rsp_hit && tex_rsp_tag_i == TAG_W'(g))
        st_q[g] <= SLOT_READY;
      else if (retire && head_tag == TAG_W'(g))
        st_q[g] <= SLOT_FREE;
    end

    always_ff @(posedge clk_i) begin
      if (accept && alloc_idx == TAG_W'(g))
        ctx_q[g] <= frag_ctx_i;
      else if (iss_valid_o && iss_tag_o == TAG_W'(g))
        ctx_q[g] <= iss_ctx_i;
    end
  end

  assert_issue_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> st_q[iss_tag_o] == SLOT_READY);
  assert_req_tag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tex_req_valid_o |-> iss_valid_o && tex_req_tag_o == iss_tag_o);
  assert_park_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tex_req_valid_o |=> st_q[$past(tex_req_tag_o)] == SLOT_WAIT);
  assert_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit |=> st_q[$past(tex_rsp_tag_i)] == SLOT_READY);
  assert_retire_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_ctx_o));
  assert_free_after_retire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire |=> frag_ready_o);
  assert_writeback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |=> ctx_q[$past(iss_tag_o)] == $past(iss_ctx_i));
endmodule

// File: tb/fts_sched_tb.sv
module fts_sched_tb;
  localparam int NS     = 8;
  localparam int TW     = 3;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frag_valid = 1'b0, frag_ready;
  logic [31:0] frag_ctx = '0;
  logic iss_valid, iss_fetch = 1'b0;
  logic [TW-1:0] iss_tag;
  logic [31:0] iss_ctx_o, iss_ctx_i = '0;
  logic tex_req_valid, tex_rsp_valid = 1'b0;
  logic [TW-1:0] tex_req_tag, tex_rsp_tag = '0;
  logic out_valid, out_ready = 1'b0;
  logic [31:0] out_ctx;

  always #(CLK_NS / 2) clk = ~clk;

  fts_sched #(.NUM_SLOTS(NS), .CTX_W(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .frag_valid_i(frag_valid), .frag_ready_o(frag_ready), .frag_ctx_i(frag_ctx),
    .iss_valid_o(iss_valid), .iss_tag_o(iss_tag), .iss_ctx_o(iss_ctx_o),
    .iss_fetch_i(iss_fetch), .iss_ctx_i(iss_ctx_i),
    .tex_req_valid_o(tex_req_valid), .tex_req_tag_o(tex_req_tag),
    .tex_rsp_valid_i(tex_rsp_valid), .tex_rsp_tag_i(tex_rsp_tag),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_ctx_o(out_ctx));

  int vectors = 0, miscompares = 0, cycles = 0;
  int m_st [NS];      // 0 free, 1 runnable, 2 parked, 3 done
  logic [31:0] m_ctx [NS];
  bit pend [NS];
  int lat [NS];
  int m_rr = 0;
  int oq [$];
  logic [31:0] eq [$];
  int lat_max = 12;
  int accepted = 0, retired = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] final_ctx(input logic [31:0] c);
    return {1'b1, c[30:8], 8'h00};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL R7 watchdog: actual %0d cycles expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic step(input bit want, input logic [31:0] fctx, input bit rdy,
                      input bit bogus, output bit took);
    bit any_free, exp_iss, exp_out, fetch, rsp_v, rsp_real;
    int exp_tag, rsp_t, start, alloc, k, h, t_iss;
    any_free = 0; alloc = 0;
    for (int s = NS - 1; s >= 0; s--) if (m_st[s] == 0) begin any_free = 1; alloc = s; end
    check(frag_ready == any_free, "R2", frag_ready, any_free);
    exp_iss = 0; exp_tag = 0;
    for (int i = 0; i < NS; i++) begin
      k = (m_rr + i) % NS;
      if (!exp_iss && m_st[k] == 1) begin exp_iss = 1; exp_tag = k; end
    end
    check(iss_valid == exp_iss, "R3", iss_valid, exp_iss);
    if (exp_iss && iss_valid) begin
      check(int'(iss_tag) == exp_tag, "R4", iss_tag, exp_tag);
      check(iss_ctx_o == m_ctx[exp_tag], "R3", iss_ctx_o, m_ctx[exp_tag]);
    end
    exp_out = (oq.size() > 0) && (m_st[oq[0]] == 3);
    check(out_valid == exp_out, "R7", out_valid, exp_out);
    if (exp_out && out_valid) check(out_ctx == eq[0], "R9", out_ctx, eq[0]);

    t_iss = int'(iss_tag);
    fetch = iss_valid && (iss_ctx_o[3:0] != 4'd0);
    iss_fetch = fetch;
    iss_ctx_i = fetch ? iss_ctx_o - 32'd1 : (iss_ctx_o | 32'h8000_0000);

    for (int s = 0; s < NS; s++) if (pend[s] && lat[s] > 0) lat[s]--;
    rsp_v = 0; rsp_real = 0; rsp_t = 0;
    start = $urandom % NS;
    for (int i = 0; i < NS; i++) begin
      k = (start + i) % NS;
      if (!rsp_v && pend[k] && lat[k] == 0) begin rsp_v = 1; rsp_real = 1; rsp_t = k; end
    end
    if (!rsp_v && bogus) begin
      for (int i = 0; i < NS; i++) begin
        k = (start + i) % NS;
        if (!rsp_v && m_st[k] != 2) begin rsp_v = 1; rsp_t = k; end
      end
    end
    tex_rsp_valid = rsp_v;
    tex_rsp_tag = TW'(rsp_t);
    frag_valid = want;
    frag_ctx = fctx;
    out_ready = rdy;
    #1;
    check(tex_req_valid == fetch, "R5", tex_req_valid, fetch);
    if (fetch) check(tex_req_tag == iss_tag, "R5", tex_req_tag, iss_tag);

    @(posedge clk);
    took = want && any_free;
    if (exp_iss) begin
      m_ctx[t_iss] = iss_ctx_i;
      m_st[t_iss] = fetch ? 2 : 3;
      if (fetch) begin pend[t_iss] = 1; lat[t_iss] = 1 + ($urandom % lat_max); end
      m_rr = (t_iss + 1) % NS;
    end
    if (rsp_real) begin m_st[rsp_t] = 1; pend[rsp_t] = 0; end
    if (exp_out && rdy) begin
      h = oq.pop_front();
      void'(eq.pop_front());
      m_st[h] = 0;
      retired++;
    end
    if (took) begin
      m_st[alloc] = 1;
      m_ctx[alloc] = fctx;
      oq.push_back(alloc);
      eq.push_back(final_ctx(fctx));
      accepted++;
    end
    @(negedge clk);
  endtask

  initial begin
    bit took;
    int n, guard, got;
    logic [31:0] f;
    for (int s = 0; s < NS; s++) begin m_st[s] = 0; m_ctx[s] = '0; pend[s] = 0; lat[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(frag_ready == 1'b1, "R1", frag_ready, 1);
    check(iss_valid == 1'b0, "R1", iss_valid, 0);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(tex_req_valid == 1'b0, "R1", tex_req_valid, 0);

    // Fill with output stalled; stray responses must be ignored (R6)
    got = 0;
    for (int i = 0; i < NS + 4; i++) begin
      f = {1'b0, 23'(i + 1), 8'h00};
      step(1'b1, f, 1'b0, 1'b1, took);
      if (took) got++;
    end
    check(got == NS, "R2", got, NS);
    check(frag_ready == 1'b0, "R2", frag_ready, 0);
    check(out_valid == 1'b1, "R7", out_valid, 1);
    step(1'b0, '0, 1'b1, 1'b0, took);
    check(frag_ready == 1'b1, "R8", frag_ready, 1);
    guard = 0;
    while (oq.size() > 0 && guard < 100) begin step(1'b0, '0, 1'b1, 1'b1, took); guard++; end

    // Random fetch counts, random latency, out-of-order responses, stalls
    n = 0;
    while (n < 400) begin
      f = {1'b0, 23'(1000 + n), 4'h0, 4'($urandom % 4)};
      if (($urandom % 10) < 7) begin
        step(1'b1, f, ($urandom % 4) != 0, ($urandom % 8) == 0, took);
        if (took) n++;
      end else begin
        step(1'b0, '0, ($urandom % 4) != 0, 1'b0, took);
      end
    end
    guard = 0;
    while (oq.size() > 0 && guard < 5000) begin step(1'b0, '0, 1'b1, 1'b0, took); guard++; end
    check(oq.size() == 0, "R7", oq.size(), 0);
    check(retired == accepted, "R7", retired, accepted);
    check(frag_ready == 1'b1, "R8", frag_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule